// File: doc/BRIEF.md
# Multiprocessor-Aware Serial Receiver

This block receives asynchronous serial characters from a single line and queues them for a host. A 16x oversampling tick paces it. The character format is set by three mode bits: 7 or 8 data bits, an optional parity bit, and 1 or 2 stop bits. A polarity input selects odd or even parity. Each character the block keeps is written into a four-entry data queue. Its error flags (overrun, framing, parity) go into a status queue of the same depth, so the two queues always describe the same character.

In multiprocessor mode, one extra bit follows the data bits in place of the parity bit. When the wake-up filter is also on, the block drops every character whose extra bit is 0. Such a character writes nothing to the queues and raises no flag. Sticky error flags collect the errors of stored characters until a one-cycle clear pulse resets them. Lowering the receive enable ends the current character at once and leaves both queues untouched.

Top module: `mp_uart_rx`

## Requirements
- R1: The line idles high. A character is a low start bit, then data bits LSB first, then an optional extra bit, then stop bits. fmt[2]=1 gives 8 data bits and fmt[2]=0 gives 7, with top_data[7] read as 0. fmt[1]=1 adds a parity bit. fmt[0]=1 gives 2 stop bits and fmt[0]=0 gives 1.
- R2: With fmt[1]=1 and mp_mode=0, the parity bit is checked. parity_odd=1 expects an odd count of ones over data plus parity, and parity_odd=0 expects an even count. A mismatch sets the entry's top_pe and flag_parity. With mp_mode=1 the extra bit is the multiprocessor bit and parity is never checked.
- R3: A stop bit sampled low sets the entry's top_fe and flag_framing. If a framing error comes with all data bits and the extra bit at 0, flag_break is also set.
- R4: With mp_mode=1 and mp_en=1, a character whose multiprocessor bit is 0 is discarded. It makes no queue write and sets no flag. A character whose bit is 1 is stored.
- R5: With mp_mode=0, mp_en has no effect and no extra bit is expected. With mp_mode=1 and mp_en=0, every character is stored.
- R6: top_mpb gives the multiprocessor bit of the oldest stored entry while mp_mode=1. It reads 0 while mp_mode=0.
- R7: top_ovr, top_fe and top_pe always belong to the same entry as top_data.
- R8: Each queue holds 4 entries. A character that would be stored while the queue is full is dropped instead. The newest stored entry then gets top_ovr=1 and flag_overrun is set.
- R9: rx_en=0 aborts any character in progress at once and blocks start detection. Stored entries and their order stay unchanged.
- R10: A one-cycle pulse on err_clear clears flag_overrun, flag_framing, flag_parity and flag_break. It does not change the queues.
- R11: A start bit counts only if the line is still low 8 ticks after the falling edge is seen. A shorter low pulse starts nothing. Every later bit is sampled 16 ticks after the previous one.
- R12: data_valid is high while the queue is not empty. A pop pulse removes the oldest entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rx | input | 1 | Serial line, idle high |
| rx_en | input | 1 | Receive enable |
| mp_mode | input | 1 | Multiprocessor format select |
| mp_en | input | 1 | Wake-up filter enable |
| fmt | input | 3 | [2] 8 data bits, [1] parity on, [0] two stop bits |
| parity_odd | input | 1 | 1 = odd parity, 0 = even |
| err_clear | input | 1 | One-cycle pulse that clears the sticky flags |
| pop | input | 1 | Remove the oldest entry |
| data_valid | output | 1 | Queue not empty |
| top_data | output | 8 | Data of the oldest entry |
| top_mpb | output | 1 | Multiprocessor bit of the oldest entry |
| top_ovr | output | 1 | Overrun mark of the oldest entry |
| top_fe | output | 1 | Framing error of the oldest entry |
| top_pe | output | 1 | Parity error of the oldest entry |
| flag_overrun | output | 1 | Sticky overrun |
| flag_framing | output | 1 | Sticky framing error |
| flag_parity | output | 1 | Sticky parity error |
| flag_break | output | 1 | Sticky break |

## Verification
The overrun mark is the hardest case to reach, because it lands on an entry that was written earlier. The bench fills the queue with four characters without popping, sends a fifth, and then drains the queue. Only the fourth entry may carry the mark, and the fifth character must be missing. The abort case is reached by dropping the enable halfway through a character, after a character has already been stored. The bench then checks that the stored character is still alone and in place, and that the next full character is received normally.

// File: rtl/uart_rx_pkg.sv
// Shared types for the serial receiver.
// Assumes: nothing beyond the definitions below.
package uart_rx_pkg;
    typedef struct packed {
        logic ovr;
        logic fe;
        logic pe;
    } rx_status_t;

    localparam int STAT_W = $bits(rx_status_t);
endpackage

// File: rtl/rx_bit_engine.sv
// Bit engine: finds start bits, samples each bit at its centre, and reports a
// finished character with its data, extra bit and framing result.
// Assumes: baud_tick is one clock wide at OSR times the bit rate, and OSR is even.
module rx_bit_engine #(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       rx,
    input  logic       rx_en,
    input  logic       mp_mode,
    input  logic [2:0] fmt,
    output logic       done,
    output logic [7:0] char_data,
    output logic       char_x,
    output logic       char_fe,
    output logic       char_par_chk
);
    localparam int CW = $clog2(OSR);
    localparam logic [CW-1:0] HALF_M1 = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] FULL_M1 = CW'(OSR - 1);

    typedef enum logic [1:0] {S_IDLE, S_START, S_BITS} st_t;

    st_t         state;
    logic [1:0]  sync;
    logic        rx_s;
    logic        armed;
    logic [CW-1:0] cnt;
    logic [3:0]  bidx;
    logic [7:0]  shreg;
    logic        xbit;
    logic        fe;
    logic        f8, fpar, ftwo, fmp;
    logic [3:0]  nd;
    logic        hasx;
    logic [3:0]  last;

    assign rx_s = sync[1];
    assign nd   = f8 ? 4'd8 : 4'd7;
    assign hasx = fpar | fmp;
    assign last = nd + {3'b0, hasx} + {3'b0, ftwo};

    // Bring the serial line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rx};
    end

    // Bit timing, sampling and character assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            armed <= 1'b0;
            cnt   <= '0;
            bidx  <= '0;
            shreg <= '0;
            xbit  <= 1'b0;
            fe    <= 1'b0;
            f8    <= 1'b0;
            fpar  <= 1'b0;
            ftwo  <= 1'b0;
            fmp   <= 1'b0;
            done  <= 1'b0;
            char_data    <= '0;
            char_x       <= 1'b0;
            char_fe      <= 1'b0;
            char_par_chk <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!rx_en) begin
                state <= S_IDLE;
                armed <= 1'b0;
            end else begin
                case (state)
                    S_IDLE: begin
                        if (rx_s) armed <= 1'b1;
                        if (baud_tick && !rx_s && armed) begin
                            state <= S_START;
                            cnt   <= '0;
                            f8    <= fmt[2];
                            fpar  <= fmt[1];
                            ftwo  <= fmt[0];
                            fmp   <= mp_mode;
                        end
                    end
                    S_START: begin
                        if (baud_tick) begin
                            if (cnt == HALF_M1) begin
                                cnt <= '0;
                                if (!rx_s) begin
                                    state <= S_BITS;
                                    bidx  <= '0;
                                    shreg <= '0;
                                    xbit  <= 1'b0;
                                    fe    <= 1'b0;
                                end else begin
                                    state <= S_IDLE;
                                end
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    S_BITS: begin
                        if (baud_tick) begin
                            if (cnt == FULL_M1) begin
                                cnt <= '0;
                                if (bidx < nd)                     shreg[bidx[2:0]] <= rx_s;
                                else if (hasx && bidx == nd)       xbit <= rx_s;
                                else if (!rx_s)                    fe <= 1'b1;
                                if (bidx == last) begin
                                    state        <= S_IDLE;
                                    armed        <= 1'b0;
                                    done         <= 1'b1;
                                    char_data    <= shreg;
                                    char_x       <= xbit;
                                    char_fe      <= fe | !rx_s;
                                    char_par_chk <= fpar & !fmp;
                                end else begin
                                    bidx <= bidx + 1'b1;
                                end
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // R9: a disabled receiver is back in idle on the next cycle.
    a_r9_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (state == S_IDLE && !done));
endmodule

// File: rtl/rx_queue.sv
// Queue of DEPTH entries, W bits each. mark ORs mark_mask into the most
// recently written entry that is still present.
// Assumes: DEPTH is a power of two, and mark is not raised in the same cycle as push.
module rx_queue #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    input  logic         mark,
    input  logic [W-1:0] mark_mask,
    output logic [W-1:0] dout,
    output logic [$clog2(DEPTH):0] level,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wptr, rptr;
    logic [AW-1:0] newest;
    logic do_push, do_pop;

    assign level   = wptr - rptr;
    assign empty   = (level == '0);
    assign full    = (level == (AW+1)'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign newest  = wptr[AW-1:0] - 1'b1;
    assign dout    = mem[rptr[AW-1:0]];

    // Advance the read and write pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
        end else begin
            if (do_push) wptr <= wptr + 1'b1;
            if (do_pop)  rptr <= rptr + 1'b1;
        end
    end

    // Write new entries and mark the newest one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) mem[e] <= '0;
        end else if (do_push) begin
            mem[wptr[AW-1:0]] <= din;
        end else if (mark && !empty) begin
            mem[newest] <= mem[newest] | mark_mask;
        end
    end

    // R8: the queue never holds more than DEPTH entries.
    a_r8_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= (AW+1)'(DEPTH));
endmodule

// File: rtl/mp_uart_rx.sv
// Serial receiver top. Applies the wake-up filter and the parity check, then
// fills the data and status queues in step and keeps the sticky flags.
// Assumes: queue depth is a power of two; err_clear and pop are one-cycle pulses.
module mp_uart_rx
    import uart_rx_pkg::*;
#(
    parameter int OSR   = 16,
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic       rx,
    input  logic       rx_en,
    input  logic       mp_mode,
    input  logic       mp_en,
    input  logic [2:0] fmt,
    input  logic       parity_odd,
    input  logic       err_clear,
    input  logic       pop,
    output logic       data_valid,
    output logic [7:0] top_data,
    output logic       top_mpb,
    output logic       top_ovr,
    output logic       top_fe,
    output logic       top_pe,
    output logic       flag_overrun,
    output logic       flag_framing,
    output logic       flag_parity,
    output logic       flag_break
);
    localparam int LW = $clog2(DEPTH) + 1;
    localparam int DW = 9;

    logic       done, cx, cfe, cpchk;
    logic [7:0] cdata;
    logic       pe, keep, store, ovr_evt, brk_evt;
    logic [DW-1:0] dq_out;
    rx_status_t    sq_in, sq_out, sq_mask;
    logic [LW-1:0] dlevel, slevel;
    logic dempty, dfull, sempty, sfull;

    rx_bit_engine #(.OSR(OSR)) i_engine (
        .clk, .rst_n, .baud_tick, .rx, .rx_en, .mp_mode, .fmt,
        .done, .char_data(cdata), .char_x(cx), .char_fe(cfe), .char_par_chk(cpchk)
    );

    assign pe      = cpchk && ((^cdata ^ cx) != parity_odd);
    assign keep    = !(mp_mode && mp_en && !cx);
    assign store   = done && keep && !dfull;
    assign ovr_evt = done && keep && dfull;
    assign brk_evt = store && cfe && (cdata == 8'h00) && !cx;

    assign sq_in   = '{ovr: 1'b0, fe: cfe, pe: pe};
    assign sq_mask = '{ovr: 1'b1, fe: 1'b0, pe: 1'b0};

    rx_queue #(.W(DW), .DEPTH(DEPTH)) i_dq (
        .clk, .rst_n, .push(store), .din({cx, cdata}), .pop,
        .mark(1'b0), .mark_mask('0), .dout(dq_out), .level(dlevel),
        .empty(dempty), .full(dfull)
    );

    rx_queue #(.W(STAT_W), .DEPTH(DEPTH)) i_sq (
        .clk, .rst_n, .push(store), .din(sq_in), .pop,
        .mark(ovr_evt), .mark_mask(sq_mask), .dout(sq_out), .level(slevel),
        .empty(sempty), .full(sfull)
    );

    assign data_valid = !dempty;
    assign top_data   = dq_out[7:0];
    assign top_mpb    = mp_mode & dq_out[8];
    assign top_ovr    = sq_out.ovr;
    assign top_fe     = sq_out.fe;
    assign top_pe     = sq_out.pe;

    // Sticky flags: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_overrun <= 1'b0;
            flag_framing <= 1'b0;
            flag_parity  <= 1'b0;
            flag_break   <= 1'b0;
        end else begin
            flag_overrun <= (flag_overrun & !err_clear) | ovr_evt;
            flag_framing <= (flag_framing & !err_clear) | (store & cfe);
            flag_parity  <= (flag_parity  & !err_clear) | (store & pe);
            flag_break   <= (flag_break   & !err_clear) | brk_evt;
        end
    end

    // R7: both queues hold the same number of entries.
    a_r7_queues_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (dlevel == slevel) && (dempty == sempty) && (dfull == sfull));

    // R4: a filtered character changes neither the queue level nor the flags.
    a_r4_filter_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mp_mode && mp_en && !cx && !pop && !err_clear)
        |=> ($stable(dlevel) && $stable(flag_framing) && $stable(flag_parity)
             && $stable(flag_overrun) && $stable(flag_break)));

    // R10: a clear with no character finishing leaves all flags low.
    a_r10_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clear && !done)
        |=> !(flag_overrun || flag_framing || flag_parity || flag_break));

    // R8: an overrun event leaves the queue full and raises the sticky flag.
    a_r8_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_evt && !pop) |=> (flag_overrun && dfull));
endmodule

// File: tb/test_mp_uart_rx.sv
module test_mp_uart_rx;
    localparam int BIT_CLK = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic baud_tick = 1'b0;
    logic rx = 1'b1;
    logic rx_en = 1'b0;
    logic mp_mode = 1'b0;
    logic mp_en = 1'b0;
    logic [2:0] fmt = 3'b100;
    logic parity_odd = 1'b0;
    logic err_clear = 1'b0;
    logic pop = 1'b0;
    logic data_valid, top_mpb, top_ovr, top_fe, top_pe;
    logic [7:0] top_data;
    logic flag_overrun, flag_framing, flag_parity, flag_break;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    // Baud tick every second clock (16x the bit rate of 32 clocks per bit).
    always @(posedge clk) baud_tick <= ~baud_tick;

    mp_uart_rx i_mp_uart_rx (
        .clk, .rst_n, .baud_tick, .rx, .rx_en, .mp_mode, .mp_en, .fmt,
        .parity_odd, .err_clear, .pop, .data_valid, .top_data, .top_mpb,
        .top_ovr, .top_fe, .top_pe, .flag_overrun, .flag_framing,
        .flag_parity, .flag_break
    );

    typedef struct packed {
        logic [2:0] fmt;
        logic       odd;
        logic       mpm;
        logic       mpe;
        logic [7:0] dat;
        logic       xb;
        logic       stop_ok;
        logic       st;
        logic [7:0] edat;
        logic       empb;
        logic       efe;
        logic       epe;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{3'b100, 1'b0, 1'b0, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b1, 8'hA5, 1'b0, 1'b0, 1'b0},
        '{3'b000, 1'b0, 1'b0, 1'b0, 8'hD5, 1'b0, 1'b1, 1'b1, 8'h55, 1'b0, 1'b0, 1'b0},
        '{3'b110, 1'b0, 1'b0, 1'b0, 8'h03, 1'b0, 1'b1, 1'b1, 8'h03, 1'b0, 1'b0, 1'b0},
        '{3'b110, 1'b0, 1'b0, 1'b0, 8'h07, 1'b0, 1'b1, 1'b1, 8'h07, 1'b0, 1'b0, 1'b1},
        '{3'b110, 1'b1, 1'b0, 1'b0, 8'h07, 1'b0, 1'b1, 1'b1, 8'h07, 1'b0, 1'b0, 1'b0},
        '{3'b101, 1'b0, 1'b0, 1'b0, 8'h3C, 1'b0, 1'b1, 1'b1, 8'h3C, 1'b0, 1'b0, 1'b0},
        '{3'b100, 1'b0, 1'b0, 1'b0, 8'h81, 1'b0, 1'b0, 1'b1, 8'h81, 1'b0, 1'b1, 1'b0},
        '{3'b011, 1'b0, 1'b0, 1'b0, 8'h11, 1'b1, 1'b1, 1'b1, 8'h11, 1'b0, 1'b0, 1'b1},
        '{3'b100, 1'b0, 1'b1, 1'b0, 8'h42, 1'b0, 1'b1, 1'b1, 8'h42, 1'b0, 1'b0, 1'b0},
        '{3'b100, 1'b0, 1'b1, 1'b1, 8'h99, 1'b1, 1'b1, 1'b1, 8'h99, 1'b1, 1'b0, 1'b0},
        '{3'b100, 1'b0, 1'b1, 1'b1, 8'h77, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        '{3'b100, 1'b0, 1'b0, 1'b1, 8'h12, 1'b0, 1'b1, 1'b1, 8'h12, 1'b0, 1'b0, 1'b0},
        '{3'b100, 1'b0, 1'b1, 1'b1, 8'h77, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
        '{3'b110, 1'b0, 1'b1, 1'b0, 8'h07, 1'b1, 1'b1, 1'b1, 8'h07, 1'b1, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_bit(input logic b);
        rx = b;
        repeat (BIT_CLK) @(negedge clk);
    endtask

    // Send one character: start, data LSB first, optional extra bit, stop bits.
    task automatic send_frame(input logic [2:0] f, input logic mpm, input logic [7:0] d,
                              input logic xb, input logic stop_ok);
        int nd = f[2] ? 8 : 7;
        @(negedge clk);
        drive_bit(1'b0);
        for (int i = 0; i < nd; i++) drive_bit(d[i]);
        if (f[1] || mpm) drive_bit(xb);
        drive_bit(stop_ok);
        if (f[0]) drive_bit(1'b1);
        drive_bit(1'b1);
        drive_bit(1'b1);
    endtask

    task automatic pulse_pop();
        @(negedge clk) pop = 1'b1;
        @(negedge clk) pop = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk) err_clear = 1'b1;
        @(negedge clk) err_clear = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state.
        check("R12 reset data_valid", data_valid, 0);
        check("R10 reset flags", {flag_overrun, flag_framing, flag_parity, flag_break}, 0);
        rx_en = 1'b1;
        repeat (BIT_CLK) @(negedge clk);

        // Table walk: R1 R2 R3 R4 R5 R6 R7.
        for (int v = 0; v < NV; v++) begin
            fmt = VECS[v].fmt;
            parity_odd = VECS[v].odd;
            mp_mode = VECS[v].mpm;
            mp_en = VECS[v].mpe;
            pulse_clear();
            send_frame(VECS[v].fmt, VECS[v].mpm, VECS[v].dat, VECS[v].xb, VECS[v].stop_ok);
            check($sformatf("R4 R5 vec%0d stored", v), data_valid, VECS[v].st);
            if (VECS[v].st) begin
                check($sformatf("R1 vec%0d data", v), top_data, VECS[v].edat);
                check($sformatf("R6 vec%0d mpb", v), top_mpb, VECS[v].empb);
                check($sformatf("R7 R3 vec%0d fe", v), top_fe, VECS[v].efe);
                check($sformatf("R7 R2 vec%0d pe", v), top_pe, VECS[v].epe);
                pulse_pop();
            end
            check($sformatf("R3 vec%0d sticky fe", v), flag_framing, VECS[v].efe);
            check($sformatf("R2 vec%0d sticky pe", v), flag_parity, VECS[v].epe);
            check($sformatf("R12 vec%0d empty", v), data_valid, 0);
        end

        // R6: top_mpb reads 0 once multiprocessor mode is turned off.
        fmt = 3'b100; mp_mode = 1'b1; mp_en = 1'b0; parity_odd = 1'b0;
        send_frame(3'b100, 1'b1, 8'h5A, 1'b1, 1'b1);
        check("R6 mpb with mode on", top_mpb, 1);
        @(negedge clk) mp_mode = 1'b0;
        @(negedge clk);
        check("R6 mpb with mode off", top_mpb, 0);
        pulse_pop();

        // R11: a short low glitch starts nothing; a real character follows.
        @(negedge clk) rx = 1'b0;
        repeat (6) @(negedge clk);
        rx = 1'b1;
        repeat (3 * BIT_CLK) @(negedge clk);
        check("R11 glitch rejected", data_valid, 0);
        send_frame(3'b100, 1'b0, 8'h3E, 1'b0, 1'b1);
        check("R11 frame after glitch", top_data, 8'h3E);
        pulse_pop();

        // R8: four stored, the fifth overruns and is dropped.
        pulse_clear();
        for (int k = 0; k < 5; k++) send_frame(3'b100, 1'b0, 8'h10 + 8'(k), 1'b0, 1'b1);
        check("R8 sticky overrun", flag_overrun, 1);
        for (int k = 0; k < 4; k++) begin
            check("R8 drain data", top_data, 8'h10 + 8'(k));
            check("R8 ovr mark", top_ovr, (k == 3) ? 1 : 0);
            pulse_pop();
        end
        check("R8 fifth dropped", data_valid, 0);

        // R3 break, then R10 clear leaves the queue alone.
        pulse_clear();
        send_frame(3'b100, 1'b0, 8'h00, 1'b0, 1'b0);
        check("R3 break flag", flag_break, 1);
        check("R3 break framing", flag_framing, 1);
        pulse_clear();
        check("R10 flags cleared", {flag_overrun, flag_framing, flag_parity, flag_break}, 0);
        check("R10 queue kept", data_valid, 1);
        check("R10 entry fe kept", top_fe, 1);
        pulse_pop();

        // R9: abort mid-character keeps the stored entry.
        send_frame(3'b100, 1'b0, 8'hC3, 1'b0, 1'b1);
        @(negedge clk);
        drive_bit(1'b0);
        drive_bit(1'b1);
        drive_bit(1'b0);
        drive_bit(1'b1);
        rx_en = 1'b0;
        rx = 1'b1;
        repeat (2 * BIT_CLK) @(negedge clk);
        rx = 1'b0;
        repeat (2 * BIT_CLK) @(negedge clk);
        rx = 1'b1;
        check("R9 entry kept", top_data, 8'hC3);
        repeat (BIT_CLK) @(negedge clk);
        rx_en = 1'b1;
        repeat (BIT_CLK) @(negedge clk);
        send_frame(3'b100, 1'b0, 8'h6D, 1'b0, 1'b1);
        check("R9 order kept", top_data, 8'hC3);
        pulse_pop();
        check("R9 next frame", top_data, 8'h6D);
        pulse_pop();
        check("R9 no stray entry", data_valid, 0);

        finish_run();
    end
endmodule